// File: doc/BRIEF.md
# Sequential Non-Restoring Divider

This block divides a dividend by a divisor of the same width and format. It uses a radix-2 non-restoring iteration that resolves one quotient bit per clock. A parameter selects unsigned or two's complement operands. Signed division runs on magnitudes, and the signs are applied at the end. A second parameter appends a number of fractional bits to the quotient. In that mode the dividend is scaled by two to the power of that count before it is divided. A final correction step adds the divisor back when the partial remainder ends negative.

The caller presents both operands with a one-cycle `start` pulse while the block is idle. The block raises `busy` and, a fixed number of cycles later, pulses `done` for one cycle. The quotient, remainder and divide-by-zero flag are updated in that same cycle. They then hold their values until the next result is written.

Top module: `nrdiv_top`

## Requirements
- R1: While idle, a high `start` at a rising edge captures `dividend` and `divisor`; both are `OPW` bits wide and share one format, unsigned when `IS_SIGNED`=0 and two's complement when `IS_SIGNED`=1.
- R2: With `IS_SIGNED`=0 and a non-zero divisor, `quotient` (`OPW+FRACW` bits) equals floor(dividend·2^FRACW / divisor), and `remainder` equals (dividend·2^FRACW) mod divisor.
- R3: With `IS_SIGNED`=1, the quotient magnitude is floor(|dividend|·2^FRACW / |divisor|), so the quotient rounds toward zero; it is negated when the operand signs differ.
- R4: With `IS_SIGNED`=1, the remainder has the magnitude (|dividend|·2^FRACW) mod |divisor| and carries the sign of the dividend; a zero remainder is zero.
- R5: The quotient is the low `OPW+FRACW` bits of the exact result; for the most negative dividend over −1 with `FRACW`=0 it wraps to the most negative value (0x80 for 8 bits).
- R6: A zero divisor gives a quotient of all ones, a remainder equal to the raw dividend, and `div_by_zero`=1, all written in the `done` cycle. A non-zero divisor writes `div_by_zero`=0.
- R7: `done` is high in the cycle after the (OPW+FRACW+2)-th rising edge that follows the edge that accepted `start`.
- R8: `done` is high for exactly one cycle per accepted operation.
- R9: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high. A `start` seen while `busy` is high is ignored and does not change the running result.
- R10: `quotient`, `remainder` and `div_by_zero` change only at the edge that raises `done`; input changes in between have no effect on them.
- R11: While `rst_n` is low, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| dividend | input | OPW | Dividend operand |
| divisor | input | OPW | Divisor operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are written |
| quotient | output | OPW+FRACW | Quotient, integer or fixed point |
| remainder | output | OPW | Remainder |
| div_by_zero | output | 1 | Divisor was zero for the latest result |

## Verification
The bench builds two copies of the block. The first has 8-bit signed operands with no fractional bits. It covers every sign pairing, rounding toward zero, the remainder sign rule, the wrap of the most negative dividend over −1, a zero divisor with a negative dividend, and a 10-cycle latency. The second has 8-bit unsigned operands with four fractional bits. It covers the scaled quotient in 12 bits, a quotient of zero with a large remainder, a full-scale dividend, a zero divisor yielding 0xFFF, and the longer 14-cycle latency. The signed copy also covers a start pulse issued while busy and output holding under changing inputs.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_CORR = 2'd2,
        ST_SIGN = 2'd3
    } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_prep.sv
module nrdiv_prep #(
    parameter int OPW       = 8,
    parameter bit IS_SIGNED = 1'b1
) (
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    output logic [OPW-1:0] a_mag,
    output logic [OPW-1:0] b_mag,
    output logic           q_neg,
    output logic           r_neg,
    output logic           b_zero
);
    assign b_zero = (b_in == '0);

    generate
        if (IS_SIGNED) begin : g_signed
            // Negating the most negative value yields 2^(OPW-1), which is
            // still a correct magnitude when read as unsigned.
            assign a_mag = a_in[OPW-1] ? (~a_in + 1'b1) : a_in;
            assign b_mag = b_in[OPW-1] ? (~b_in + 1'b1) : b_in;
            assign q_neg = a_in[OPW-1] ^ b_in[OPW-1];
            assign r_neg = a_in[OPW-1];
        end else begin : g_unsigned
            assign a_mag = a_in;
            assign b_mag = b_in;
            assign q_neg = 1'b0;
            assign r_neg = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int QW = 8,
    parameter int PW = 10
) (
    input  logic [PW-1:0] p_in,
    input  logic [QW-1:0] q_in,
    input  logic [PW-1:0] d_in,
    output logic [PW-1:0] p_out,
    output logic [QW-1:0] q_out
);
    logic [PW-1:0] shifted;

    always_comb begin
        shifted = {p_in[PW-2:0], q_in[QW-1]};
        // Sign of the old partial remainder picks subtract or add.
        p_out   = p_in[PW-1] ? (shifted + d_in) : (shifted - d_in);
        q_out   = {q_in[QW-2:0], ~p_out[PW-1]};
    end
endmodule

// File: rtl/nrdiv_sign.sv
module nrdiv_sign #(
    parameter int OPW = 8,
    parameter int QW  = 8
) (
    input  logic [QW-1:0]  q_mag,
    input  logic [OPW-1:0] r_mag,
    input  logic           q_neg,
    input  logic           r_neg,
    input  logic           zero_div,
    input  logic [OPW-1:0] a_raw,
    output logic [QW-1:0]  q_out,
    output logic [OPW-1:0] r_out
);
    always_comb begin
        if (zero_div) begin
            q_out = '1;
            r_out = a_raw;
        end else begin
            q_out = q_neg ? (~q_mag + 1'b1) : q_mag;
            r_out = r_neg ? (~r_mag + 1'b1) : r_mag;
        end
    end
endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
    import nrdiv_pkg::*;
#(
    parameter int OPW       = 8,
    parameter int FRACW     = 0,
    parameter bit IS_SIGNED = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [OPW-1:0]        dividend,
    input  logic [OPW-1:0]        divisor,
    output logic                  busy,
    output logic                  done,
    output logic [OPW+FRACW-1:0]  quotient,
    output logic [OPW-1:0]        remainder,
    output logic                  div_by_zero
);
    localparam int QW = OPW + FRACW;
    localparam int PW = OPW + 2;
    localparam int CW = $clog2(QW + 1);

    typedef struct packed {
        nrdiv_state_e   state;
        logic [CW-1:0]  cnt;
        logic [PW-1:0]  p;
        logic [QW-1:0]  q;
        logic [PW-1:0]  d;
        logic [OPW-1:0] a_raw;
        logic           q_neg;
        logic           r_neg;
        logic           zero;
        logic [QW-1:0]  quot;
        logic [OPW-1:0] rem;
        logic           dbz;
        logic           done;
    } nrdiv_regs_t;

    nrdiv_regs_t r_q, r_d;

    logic [OPW-1:0] a_mag, b_mag;
    logic           q_neg, r_neg, b_zero;
    logic [PW-1:0]  step_p;
    logic [QW-1:0]  step_q;
    logic [QW-1:0]  fin_q;
    logic [OPW-1:0] fin_r;

    nrdiv_prep #(.OPW(OPW), .IS_SIGNED(IS_SIGNED)) u_prep (
        .a_in(dividend), .b_in(divisor),
        .a_mag(a_mag), .b_mag(b_mag),
        .q_neg(q_neg), .r_neg(r_neg), .b_zero(b_zero)
    );

    nrdiv_step #(.QW(QW), .PW(PW)) u_step (
        .p_in(r_q.p), .q_in(r_q.q), .d_in(r_q.d),
        .p_out(step_p), .q_out(step_q)
    );

    nrdiv_sign #(.OPW(OPW), .QW(QW)) u_sign (
        .q_mag(r_q.q), .r_mag(r_q.p[OPW-1:0]),
        .q_neg(r_q.q_neg), .r_neg(r_q.r_neg),
        .zero_div(r_q.zero), .a_raw(r_q.a_raw),
        .q_out(fin_q), .r_out(fin_r)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_ITER;
                    r_d.cnt   = '0;
                    r_d.p     = '0;
                    r_d.q     = '0;
                    r_d.q[QW-1 -: OPW] = a_mag;   // dividend scaled by 2^FRACW
                    r_d.d     = PW'(b_mag);
                    r_d.a_raw = dividend;
                    r_d.q_neg = q_neg;
                    r_d.r_neg = r_neg;
                    r_d.zero  = b_zero;
                end
            end
            ST_ITER: begin
                r_d.p   = step_p;
                r_d.q   = step_q;
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(QW - 1)) begin
                    r_d.state = ST_CORR;
                end
            end
            ST_CORR: begin
                if (r_q.p[PW-1]) begin
                    r_d.p = r_q.p + r_q.d;
                end
                r_d.state = ST_SIGN;
            end
            default: begin
                r_d.quot  = fin_q;
                r_d.rem   = fin_r;
                r_d.dbz   = r_q.zero;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.state != ST_IDLE);
    assign done        = r_q.done;
    assign quotient    = r_q.quot;
    assign remainder   = r_q.rem;
    assign div_by_zero = r_q.dbz;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r10_hold_quot: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

    a_r6_zero_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero |-> (quotient == '1));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.state == ST_ITER && r_q.cnt != CW'(QW - 1)) |=> (r_q.state == ST_ITER));
endmodule

// File: tb/nrdiv_top_test.sv
`timescale 1ns/1ps
module nrdiv_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // signed integer instance
    logic        s_start = 1'b0;
    logic [7:0]  s_a = '0, s_b = '0;
    logic        s_busy, s_done, s_dbz;
    logic [7:0]  s_q, s_r;

    // unsigned instance with 4 fractional bits
    logic        f_start = 1'b0;
    logic [7:0]  f_a = '0, f_b = '0;
    logic        f_busy, f_done, f_dbz;
    logic [11:0] f_q;
    logic [7:0]  f_r;

    nrdiv_top #(.OPW(8), .FRACW(0), .IS_SIGNED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start(s_start),
        .dividend(s_a), .divisor(s_b),
        .busy(s_busy), .done(s_done),
        .quotient(s_q), .remainder(s_r), .div_by_zero(s_dbz)
    );

    nrdiv_top #(.OPW(8), .FRACW(4), .IS_SIGNED(1'b0)) uut_frac (
        .clk(clk), .rst_n(rst_n), .start(f_start),
        .dividend(f_a), .divisor(f_b),
        .busy(f_busy), .done(f_done),
        .quotient(f_q), .remainder(f_r), .div_by_zero(f_dbz)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_s(input logic [7:0] a, input logic [7:0] b, output int lat);
        @(negedge clk);
        s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        lat = 0;
        while (!s_done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_f(input logic [7:0] a, input logic [7:0] b, output int lat);
        @(negedge clk);
        f_a = a; f_b = b; f_start = 1'b1;
        @(negedge clk);
        f_start = 1'b0;
        lat = 0;
        while (!f_done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 busy", {31'd0, s_busy}, 0);
        chk("R11 done", {31'd0, s_done}, 0);
        chk("R11 dbz", {31'd0, s_dbz}, 0);
        chk("R11 quotient", {24'd0, s_q}, 0);
        chk("R11 remainder", {24'd0, s_r}, 0);
        chk("R11 frac quotient", {20'd0, f_q}, 0);
    endtask

    task automatic t_signed(input int a, input int b);
        int lat;
        int eq, er;
        run_s(8'(a), 8'(b), lat);
        eq = a / b;
        er = a % b;
        chk("R7 signed latency", lat, 10);
        chk("R3 signed quotient", {24'd0, s_q}, {24'd0, 8'(eq)});
        chk("R4 signed remainder", {24'd0, s_r}, {24'd0, 8'(er)});
        chk("R6 dbz clear", {31'd0, s_dbz}, 0);
        @(negedge clk);
        chk("R8 done one cycle", {31'd0, s_done}, 0);
    endtask

    task automatic t_wrap();
        int lat;
        run_s(8'h80, 8'hFF, lat);
        chk("R5 wrap quotient", {24'd0, s_q}, 32'h80);
        chk("R5 wrap remainder", {24'd0, s_r}, 0);
    endtask

    task automatic t_zero_signed();
        int lat;
        run_s(8'hDB, 8'h00, lat);
        chk("R7 latency on zero divisor", lat, 10);
        chk("R6 zero quotient", {24'd0, s_q}, 32'hFF);
        chk("R6 zero remainder", {24'd0, s_r}, 32'hDB);
        chk("R6 zero flag", {31'd0, s_dbz}, 1);
    endtask

    task automatic t_frac(input int a, input int b);
        int lat;
        int eq, er;
        run_f(8'(a), 8'(b), lat);
        eq = (a * 16) / b;
        er = (a * 16) % b;
        chk("R7 frac latency", lat, 14);
        chk("R2 frac quotient", {20'd0, f_q}, {20'd0, 12'(eq)});
        chk("R2 frac remainder", {24'd0, f_r}, {24'd0, 8'(er)});
        chk("R6 frac dbz clear", {31'd0, f_dbz}, 0);
    endtask

    task automatic t_zero_frac();
        int lat;
        run_f(8'd5, 8'd0, lat);
        chk("R6 frac zero quotient", {20'd0, f_q}, 32'hFFF);
        chk("R6 frac zero remainder", {24'd0, f_r}, 5);
        chk("R6 frac zero flag", {31'd0, f_dbz}, 1);
    endtask

    task automatic t_busy_ignore();
        int lat;
        @(negedge clk);
        s_a = 8'd100; s_b = 8'd7; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk("R9 busy after start", {31'd0, s_busy}, 1);
        chk("R1 no early done", {31'd0, s_done}, 0);
        @(negedge clk);
        @(negedge clk);
        s_a = 8'hCE; s_b = 8'd3; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        lat = 3;
        while (!s_done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 ignored start latency", lat, 10);
        chk("R9 ignored start quotient", {24'd0, s_q}, 14);
        chk("R9 ignored start remainder", {24'd0, s_r}, 2);
        chk("R9 busy low at done", {31'd0, s_busy}, 0);
        @(negedge clk);
        chk("R9 no second result", {31'd0, s_done}, 0);
        chk("R9 idle after", {31'd0, s_busy}, 0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        s_a = 8'h11; s_b = 8'h05;
        repeat (6) @(negedge clk);
        chk("R10 hold quotient", {24'd0, s_q}, 14);
        chk("R10 hold remainder", {24'd0, s_r}, 2);
        chk("R10 no done", {31'd0, s_done}, 0);
    endtask

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_signed(100, 7);
        t_signed(-100, 7);
        t_signed(100, -7);
        t_signed(-100, -7);
        t_signed(-6, 3);
        t_signed(127, 1);
        t_signed(3, 50);
        t_wrap();
        t_zero_signed();
        t_signed(9, 4);
        t_frac(200, 3);
        t_frac(1, 3);
        t_frac(7, 200);
        t_frac(255, 1);
        t_zero_frac();
        t_frac(255, 255);
        t_busy_ignore();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule